// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block sits between a set of interrupt sources and a processor core. It keeps one pending flag, one enable bit and one 3-bit priority for each of `N_SRC` ordinary sources. It also takes six processor trap lines that cannot be masked. On every clock it picks the most urgent eligible request. If that request's level is strictly above the level the core is running at, the block raises a request toward the core together with a vector number and a level.

When the core acknowledges a raised request, the vector and level are frozen in a holding register. They stay there until the next acknowledged request. Flags are set by one-cycle request pulses and cleared only through the register write port, so the handler clears its own source. Traps take fixed levels 8 to 13, which are above any ordinary source.

The control is a two-state machine. `ST_QUIET` means no request is presented to the core. `ST_ASSERT` means a request is presented. The transition *raise* goes from `ST_QUIET` to `ST_ASSERT` when a winner beats the core level. *Drop* goes from `ST_ASSERT` to `ST_QUIET` when no winner beats it. *Hold* keeps `ST_ASSERT` and refreshes the vector and level. *Idle* keeps `ST_QUIET`. All of these are taken on each clock from the winner sampled at that edge.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_req`, `irq_vec`, `irq_lvl`, `held_vec` and `held_lvl` are zero, and every flag, enable and priority is zero.
- R2: A write with `wr_en` high uses `wr_addr[IDX_W+1:IDX_W]` as the field and `wr_addr[IDX_W-1:0]` as the source index. The field codes are: 0 writes the flag from `wr_data[0]`, 1 writes the enable from `wr_data[0]`, and 2 writes the priority from `wr_data[2:0]`. Field 3 changes nothing.
- R3: A high `src_req[j]` at a clock edge sets flag j. It wins over a clear of the same flag written in the same cycle. A flag stays set until written to 0, and an acknowledge does not clear it.
- R4: An ordinary source takes part only when its flag is set, its enable is 1 and its priority is not 0.
- R5: Among taking-part ordinary sources, the highest priority wins. On a tie, the lower source index wins. Ordinary source j reports vector 8+j and its priority as level.
- R6: A high `trap_in[i]` takes part with fixed level 8+i and vector i, needing no enable. Any trap beats every ordinary source, and the highest active trap index wins.
- R7: `irq_req` is high only when the winner's level is strictly greater than `cpu_level`. While `irq_req` is low, `irq_vec` and `irq_lvl` are 0.
- R8: `irq_req`, `irq_vec` and `irq_lvl` are registered from the flags, enables, priorities, traps and `cpu_level` as they stood at the previous edge. A flag set at edge k shows at the outputs after edge k+1.
- R9: `ack` high at an edge where `irq_req` is high copies `irq_vec`/`irq_lvl` into `held_vec`/`held_lvl`. At any other edge the holding register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | N_SRC | Request pulses, one per ordinary source |
| trap_in | input | 6 | Processor trap lines, level sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+2 | Field code and source index |
| wr_data | input | 3 | Write data |
| cpu_level | input | 4 | Level the core currently runs at |
| ack | input | 1 | Core acknowledge |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector of the presented request |
| irq_lvl | output | 4 | Level of the presented request |
| held_vec | output | VEC_W | Vector frozen on acknowledge |
| held_lvl | output | 4 | Level frozen on acknowledge |

## Verification
The assertions watch, on every cycle, the rules that relate outputs to inputs one edge earlier. A raised request always beats the previous core level, and a quiet output carries zero vector and level. An active trap under a low core level always produces a trap-level request. The holding register either copies the presented request on acknowledge or keeps its value. Which source wins a priority tie, whether a same-cycle request pulse overrides a flag clear, that an acknowledge leaves flags set, and that disabled or priority-0 sources stay silent are shown only by the bench's scenarios. In those scenarios a behavioural model predicts the outputs on each clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_TRAP          = 6;
    localparam int LVL_W           = 4;
    localparam int PRIO_W          = 3;
    localparam int TRAP_BASE_LVL   = 8;
    localparam int PERIPH_VEC_BASE = 8;

    typedef enum logic [1:0] {
        FLD_FLAG = 2'd0,
        FLD_EN   = 2'd1,
        FLD_PRIO = 2'd2,
        FLD_NONE = 2'd3
    } irq_field_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_ASSERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              src_req,
    input  logic                          wr_en,
    input  logic [IDX_W+1:0]              wr_addr,
    input  logic [PRIO_W-1:0]             wr_data,
    output logic [N_SRC-1:0]              flags,
    output logic [N_SRC-1:0]              enables,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prios
);
    irq_field_e fld;
    assign fld = irq_field_e'(wr_addr[IDX_W+1:IDX_W]);

    for (genvar j = 0; j < N_SRC; j++) begin : g_src
        logic hit;
        assign hit = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[j]   <= 1'b0;
                enables[j] <= 1'b0;
                prios[j]   <= '0;
            end else begin
                if (hit && fld == FLD_FLAG) flags[j]   <= wr_data[0];
                if (hit && fld == FLD_EN)   enables[j] <= wr_data[0];
                if (hit && fld == FLD_PRIO) prios[j]   <= wr_data;
                if (src_req[j])             flags[j]   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_pkg::*;
#(
    parameter int N_SRC = 16,
    parameter int VEC_W = $clog2(PERIPH_VEC_BASE + N_SRC)
) (
    input  logic [N_SRC-1:0]              flags,
    input  logic [N_SRC-1:0]              enables,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prios,
    input  logic [N_TRAP-1:0]             trap_in,
    output logic                          win_valid,
    output logic [VEC_W-1:0]              win_vec,
    output logic [LVL_W-1:0]              win_lvl
);
    always_comb begin
        logic [LVL_W-1:0] eff;
        win_lvl = '0;
        win_vec = '0;
        // ordinary sources: strict compare keeps the lower index on ties
        for (int j = 0; j < N_SRC; j++) begin
            eff = (flags[j] && enables[j]) ? LVL_W'(prios[j]) : '0;
            if (eff > win_lvl) begin
                win_lvl = eff;
                win_vec = VEC_W'(PERIPH_VEC_BASE + j);
            end
        end
        // traps: ascending scan, so the highest active index ends up selected
        for (int i = 0; i < N_TRAP; i++) begin
            if (trap_in[i]) begin
                win_lvl = LVL_W'(TRAP_BASE_LVL + i);
                win_vec = VEC_W'(i);
            end
        end
        win_valid = (win_lvl != '0);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int VEC_W = $clog2(PERIPH_VEC_BASE + N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_req,
    input  logic [N_TRAP-1:0]     trap_in,
    input  logic                  wr_en,
    input  logic [IDX_W+1:0]      wr_addr,
    input  logic [PRIO_W-1:0]     wr_data,
    input  logic [LVL_W-1:0]      cpu_level,
    input  logic                  ack,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vec,
    output logic [LVL_W-1:0]      irq_lvl,
    output logic [VEC_W-1:0]      held_vec,
    output logic [LVL_W-1:0]      held_lvl
);
    logic [N_SRC-1:0]             flags;
    logic [N_SRC-1:0]             enables;
    logic [N_SRC-1:0][PRIO_W-1:0] prios;
    logic                         win_valid;
    logic [VEC_W-1:0]             win_vec;
    logic [LVL_W-1:0]             win_lvl;
    logic                         beats;

    irq_state_e state_q, state_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;

    irq_regs #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .flags   (flags),
        .enables (enables),
        .prios   (prios)
    );

    irq_select #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_select (
        .flags     (flags),
        .enables   (enables),
        .prios     (prios),
        .trap_in   (trap_in),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_lvl   (win_lvl)
    );

    assign beats = win_valid && (win_lvl > cpu_level);

    // next state and registered payload
    always_comb begin
        state_d = state_q;
        vec_d   = '0;
        lvl_d   = '0;
        unique case (state_q)
            ST_QUIET: begin
                if (beats) state_d = ST_ASSERT;   // raise
            end
            ST_ASSERT: begin
                if (!beats) state_d = ST_QUIET;   // drop, else hold
            end
            default: state_d = ST_QUIET;
        endcase
        if (beats) begin
            vec_d = win_vec;
            lvl_d = win_lvl;
        end
    end

    // state register, request payload and holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_QUIET;
            vec_q    <= '0;
            lvl_q    <= '0;
            held_vec <= '0;
            held_lvl <= '0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            lvl_q   <= lvl_d;
            if (ack && state_q == ST_ASSERT) begin
                held_vec <= vec_q;
                held_lvl <= lvl_q;
            end
        end
    end

    // outputs from state
    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        irq_lvl = '0;
        unique case (state_q)
            ST_QUIET: ;
            ST_ASSERT: begin
                irq_req = 1'b1;
                irq_vec = vec_q;
                irq_lvl = lvl_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_arbiter_sva.sv
module irq_arbiter_sva
    import irq_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TRAP-1:0] trap_in,
    input logic [LVL_W-1:0]  cpu_level,
    input logic              ack,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [LVL_W-1:0]  irq_lvl,
    input logic [VEC_W-1:0]  held_vec,
    input logic [LVL_W-1:0]  held_lvl
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_req_beats_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && irq_req) |-> (irq_lvl > $past(cpu_level)));

    assert_quiet_payload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0 && irq_lvl == '0));

    assert_trap_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(|trap_in) && $past(cpu_level) < LVL_W'(TRAP_BASE_LVL))
        |-> (irq_req && irq_lvl >= LVL_W'(TRAP_BASE_LVL) && irq_vec < VEC_W'(N_TRAP)));

    assert_ack_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (held_vec == $past(irq_vec) && held_lvl == $past(irq_lvl)));

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq_req) |=> ($stable(held_vec) && $stable(held_lvl)));
endmodule

bind irq_arbiter irq_arbiter_sva #(.VEC_W(VEC_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_in   (trap_in),
    .cpu_level (cpu_level),
    .ack       (ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_lvl   (irq_lvl),
    .held_vec  (held_vec),
    .held_lvl  (held_lvl)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
    localparam int N   = 16;
    localparam int AW  = 6;
    localparam int VW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_req = '0;
    logic [5:0]    trap_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [2:0]    wr_data = '0;
    logic [3:0]    cpu_level = '0;
    logic          ack = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic [3:0]    irq_lvl;
    logic [VW-1:0] held_vec;
    logic [3:0]    held_lvl;

    irq_arbiter #(.N_SRC(N)) u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_in(trap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_level(cpu_level), .ack(ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .held_vec(held_vec), .held_lvl(held_lvl)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    string cur = "R1";

    // behavioural model state
    bit mf[N];
    bit me[N];
    int mp[N];
    bit m_req;
    int m_vec, m_lvl, m_hv, m_hl;

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    task automatic compare();
        vectors++;
        if (irq_req !== m_req || irq_vec !== VW'(m_vec) || irq_lvl !== 4'(m_lvl) ||
            held_vec !== VW'(m_hv) || held_lvl !== 4'(m_hl)) begin
            errors++;
            $display("FAIL %s t=%0t actual req=%0d vec=%0d lvl=%0d hv=%0d hl=%0d expected req=%0d vec=%0d lvl=%0d hv=%0d hl=%0d",
                     cur, $time, irq_req, irq_vec, irq_lvl, held_vec, held_lvl,
                     m_req, m_vec, m_lvl, m_hv, m_hl);
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // one clock: model advances from pre-edge state, then compare after the edge
    task automatic tick();
        int lvl, vec;
        @(posedge clk);
        if (ack && m_req) begin m_hv = m_vec; m_hl = m_lvl; end
        lvl = 0; vec = 0;
        for (int t = 5; t >= 0; t--)
            if (trap_in[t] && lvl == 0) begin lvl = 8 + t; vec = t; end
        for (int L = 7; L >= 1 && lvl == 0; L--)
            for (int j = 0; j < N && lvl == 0; j++)
                if (mf[j] && me[j] && mp[j] == L) begin lvl = L; vec = 8 + j; end
        m_req = (lvl > int'(cpu_level));
        m_vec = m_req ? vec : 0;
        m_lvl = m_req ? lvl : 0;
        if (wr_en) begin
            case (wr_addr[5:4])
                2'd0: mf[wr_addr[3:0]] = wr_data[0];
                2'd1: me[wr_addr[3:0]] = wr_data[0];
                2'd2: mp[wr_addr[3:0]] = int'(wr_data);
                default: ;
            endcase
        end
        for (int j = 0; j < N; j++) if (src_req[j]) mf[j] = 1'b1;
        #1;
        compare();
    endtask

    task automatic wr(int fld, int idx, int d);
        wr_en = 1'b1; wr_addr = {2'(fld), 4'(idx)}; wr_data = 3'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse(int j);
        src_req[j] = 1'b1;
        tick();
        src_req = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) begin mf[j] = 0; me[j] = 0; mp[j] = 0; end
        m_req = 0; m_vec = 0; m_lvl = 0; m_hv = 0; m_hl = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        cur = "R1";
        tick();
        chk("R1", int'(irq_req), 0);
        chk("R1", int'(held_vec), 0);

        // R2 / R4: configure source 3, no flag yet
        cur = "R2";
        wr(1, 3, 1);
        wr(2, 3, 5);
        wr(3, 3, 7);          // field 3 ignored
        tick();
        chk("R4", int'(irq_req), 0);

        // R3 / R8: pulse shows one edge after the flag
        cur = "R8";
        pulse(3);
        chk("R8", int'(irq_req), 0);
        tick();
        chk("R8", int'(irq_req), 1);
        chk("R5", int'(irq_vec), 11);
        chk("R5", int'(irq_lvl), 5);

        // R7: strict level compare
        cur = "R7";
        cpu_level = 5; tick(); tick();
        chk("R7", int'(irq_req), 0);
        cpu_level = 4; tick(); tick();
        chk("R7", int'(irq_req), 1);
        cpu_level = 0;

        // R5: tie goes to lower index, higher priority wins
        cur = "R5";
        wr(1, 1, 1); wr(2, 1, 5); pulse(1); tick();
        chk("R5", int'(irq_vec), 9);
        wr(1, 10, 1); wr(2, 10, 7); pulse(10); tick();
        chk("R5", int'(irq_vec), 18);

        // R4: priority 0 and enable 0 remove a source
        cur = "R4";
        wr(2, 10, 0); tick();
        chk("R4", int'(irq_vec), 9);
        wr(1, 1, 0); tick();
        chk("R4", int'(irq_vec), 11);

        // R6: traps
        cur = "R6";
        trap_in = 6'b000001; tick();
        chk("R6", int'(irq_vec), 0);
        chk("R6", int'(irq_lvl), 8);
        trap_in = 6'b100101; tick();
        chk("R6", int'(irq_vec), 5);
        chk("R6", int'(irq_lvl), 13);
        cpu_level = 13; tick(); tick();
        chk("R6", int'(irq_req), 0);
        cpu_level = 0; trap_in = '0; tick(); tick();

        // R9: acknowledge latch and hold
        cur = "R9";
        ack = 1'b1; tick(); ack = 1'b0;
        chk("R9", int'(held_vec), 11);
        chk("R9", int'(held_lvl), 5);
        trap_in = 6'b000010; tick(); tick();
        chk("R9", int'(held_vec), 11);
        trap_in = '0;
        cpu_level = 15; tick(); tick();
        ack = 1'b1; tick(); ack = 1'b0;
        chk("R9", int'(held_vec), 11);
        cpu_level = 0; tick(); tick();

        // R3: ack left the flag set; set wins over same-cycle clear
        cur = "R3";
        chk("R3", int'(irq_req), 1);
        wr_en = 1'b1; wr_addr = {2'd0, 4'd3}; wr_data = 3'd0; src_req[3] = 1'b1;
        tick();
        wr_en = 1'b0; src_req = '0;
        tick();
        chk("R3", int'(irq_vec), 11);
        wr(0, 3, 0); tick();
        chk("R3", int'(irq_req), 0);

        // mixed random traffic
        cur = "R5";
        for (int k = 0; k < 4000; k++) begin
            src_req   = N'($urandom) & N'($urandom);
            wr_en     = ($urandom_range(0, 2) == 0);
            wr_addr   = AW'($urandom);
            wr_data   = 3'($urandom);
            trap_in   = ($urandom_range(0, 9) == 0) ? 6'($urandom) : 6'd0;
            cpu_level = 4'($urandom_range(0, 9));
            ack       = ($urandom_range(0, 3) == 0);
            tick();
        end

        report();
        $finish;
    end
endmodule